// File: doc/BRIEF.md
# Counter-Mode Block Sequence Generator

This block supplies the stream of 128-bit input blocks that a block-cipher engine running in counter mode encrypts, one block for each 16 bytes of payload. Software writes only the starting 128-bit initialization value. From then on the hardware steps the counter on every accepted advance request. Software does not touch the count again.

A width select sets how much of the 128-bit value counts. The rest is a fixed nonce. The counter always sits in the low-order bytes and counts as a big-endian integer. The carry stays inside the counter field and never reaches the nonce. A sticky flag reports that the counter field has rolled over to zero, which warns that keystream blocks are about to repeat. The width select is captured when a new initialization value is loaded, so one stream keeps a single split from start to end.

Top module: `ctr_blockgen`

## Requirements
- R1: While `rst` is high at a rising edge, the block clears state. After that edge, `adv_ready` is 0, `wrap_flag` is 0 and `blk_out` is all zeros.
- R2: At the edge after `iv_load` is sampled high, `blk_out` equals `iv_data` unchanged, `adv_ready` is 1 and `wrap_flag` is 0. A load takes priority over an advance requested in the same cycle.
- R3: An advance is accepted at an edge where `adv_valid` and `adv_ready` are both high. After that edge, the counter field of `blk_out` is one greater. The increment is big-endian, so `blk_out[7:0]` (byte 15) is the least significant byte.
- R4: At an edge with no accepted advance and no load, `blk_out` keeps its value. Before the first load, `adv_ready` is 0 and `adv_valid` has no effect.
- R5: Width codes 2'b00 and 2'b11 make all 128 bits a single counter, with carries passing through every byte.
- R6: Width code 2'b01 makes `blk_out[63:0]` the counter. `blk_out[127:64]` is a nonce that never changes on an advance, even when the counter rolls over.
- R7: Width code 2'b10 makes `blk_out[31:0]` the counter. `blk_out[127:32]` is a nonce that never changes on an advance, even when the counter rolls over.
- R8: `wrap_flag` rises at the edge where an accepted advance turns the counter field from all ones to zero. It stays high through later advances.
- R9: Only a load clears `wrap_flag`.
- R10: The width code is sampled when `iv_load` is high. Changes to `mode` at any other time have no effect on the running stream.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| iv_load | input | 1 | Load `iv_data` and capture `mode` |
| iv_data | input | 128 | Starting counter block (nonce high, counter low) |
| mode | input | 2 | Counter width: 00 = 128, 01 = 64, 10 = 32, 11 = 128 |
| adv_valid | input | 1 | Request to step to the next block |
| adv_ready | output | 1 | High once a starting value has been loaded |
| blk_out | output | 128 | Current counter block |
| wrap_flag | output | 1 | Sticky rollover of the counter field |

## Verification
Each width code is loaded with values chosen to separate the cases. Small counts check plain increments. Values with all-ones runs just below a segment boundary show whether the carry crosses it. Values with the whole counter field at all ones show whether the carry stops at the nonce and raises the rollover flag. In the 128-bit mode, a carry across the 64-bit boundary must reach the upper half. With the same pattern in the 64-bit mode, the nonce must stay put. This pair tells a correct width decode from a fixed one. Directed cases cover advancing before any load, a load and an advance in the same cycle, a stuck flag across later advances, and a width change after a load.

// File: rtl/ctr_pkg.sv
package ctr_pkg;

    typedef enum logic [1:0] {
        CW_FULL    = 2'b00,
        CW_HALF    = 2'b01,
        CW_QUARTER = 2'b10,
        CW_ALIAS   = 2'b11
    } ctr_width_e;

    typedef struct packed {
        logic       loaded;
        logic       wrapped;
        ctr_width_e width;
    } ctr_state_t;

    // number of low-order bits that count for a given width code
    function automatic int unsigned field_bits(input ctr_width_e w, input int unsigned blk_w);
        case (w)
            CW_HALF:    return blk_w / 2;
            CW_QUARTER: return blk_w / 4;
            default:    return blk_w;
        endcase
    endfunction

endpackage

// File: rtl/ctr_mode_dec.sv
module ctr_mode_dec
    import ctr_pkg::*;
#(
    parameter int unsigned BLK_W = 128,
    parameter int unsigned SEG_W = 32,
    localparam int unsigned N_SEG = BLK_W / SEG_W
) (
    input  ctr_width_e       width,
    output logic [N_SEG-1:0] seg_en
);
    for (genvar i = 0; i < N_SEG; i++) begin : g_en
        assign seg_en[i] = (i * SEG_W) < field_bits(width, BLK_W);
    end
endmodule

// File: rtl/ctr_seg_inc.sv
module ctr_seg_inc #(
    parameter int unsigned SEG_W = 32
) (
    input  logic [SEG_W-1:0] val,
    input  logic             en,
    input  logic             cin,
    output logic [SEG_W-1:0] sum,
    output logic             cout
);
    logic [SEG_W:0] ext;

    always_comb begin
        if (en) ext = {1'b0, val} + {{SEG_W{1'b0}}, cin};
        else    ext = {1'b0, val};
    end

    assign sum  = ext[SEG_W-1:0];
    assign cout = ext[SEG_W];
endmodule

// File: rtl/ctr_blockgen.sv
module ctr_blockgen
    import ctr_pkg::*;
#(
    parameter int unsigned BLK_W = 128,
    parameter int unsigned SEG_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             iv_load,
    input  logic [BLK_W-1:0] iv_data,
    input  logic [1:0]       mode,
    input  logic             adv_valid,
    output logic             adv_ready,
    output logic [BLK_W-1:0] blk_out,
    output logic             wrap_flag
);
    localparam int unsigned N_SEG = BLK_W / SEG_W;

    ctr_state_t       st_q;
    logic [BLK_W-1:0] ctr_q, ctr_d;
    logic [N_SEG-1:0] seg_en;
    logic [N_SEG:0]   carry;
    logic             accept, wrap_hit;

    assign accept   = adv_valid && st_q.loaded;
    assign carry[0] = accept;

    ctr_mode_dec #(.BLK_W(BLK_W), .SEG_W(SEG_W)) u_dec (
        .width  (st_q.width),
        .seg_en (seg_en)
    );

    for (genvar i = 0; i < N_SEG; i++) begin : g_seg
        ctr_seg_inc #(.SEG_W(SEG_W)) u_inc (
            .val  (ctr_q[i*SEG_W +: SEG_W]),
            .en   (seg_en[i]),
            .cin  (carry[i]),
            .sum  (ctr_d[i*SEG_W +: SEG_W]),
            .cout (carry[i+1])
        );
    end

    // rollover = carry out of the highest enabled segment
    always_comb begin
        wrap_hit = 1'b0;
        for (int i = 0; i < N_SEG; i++) begin
            if (seg_en[i] && (i == N_SEG - 1 || !seg_en[(i + 1) % N_SEG]))
                wrap_hit = wrap_hit | carry[i+1];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctr_q        <= '0;
            st_q.loaded  <= 1'b0;
            st_q.wrapped <= 1'b0;
            st_q.width   <= CW_FULL;
        end else if (iv_load) begin
            ctr_q        <= iv_data;
            st_q.loaded  <= 1'b1;
            st_q.wrapped <= 1'b0;
            st_q.width   <= ctr_width_e'(mode);
        end else if (accept) begin
            ctr_q <= ctr_d;
            if (wrap_hit) st_q.wrapped <= 1'b1;
        end
    end

    assign adv_ready = st_q.loaded;
    assign blk_out   = ctr_q;
    assign wrap_flag = st_q.wrapped;
endmodule

// File: rtl/ctr_blockgen_chk.sv
module ctr_blockgen_chk #(
    parameter int unsigned BLK_W = 128,
    parameter int unsigned SEG_W = 32
) (
    input logic             clk,
    input logic             rst,
    input logic             iv_load,
    input logic [BLK_W-1:0] iv_data,
    input logic             adv_valid,
    input logic             adv_ready,
    input logic [BLK_W-1:0] blk_out,
    input logic             wrap_flag,
    input logic [1:0]       width_q
);
    logic acc;
    assign acc = adv_valid && adv_ready && !iv_load;

    a_r1_reset_clears: assert property (@(posedge clk)
        rst |=> (!adv_ready && !wrap_flag && blk_out == '0));

    a_r2_load_takes_iv: assert property (@(posedge clk) disable iff (rst)
        iv_load |=> (blk_out == $past(iv_data) && adv_ready && !wrap_flag));

    a_r3_low_step: assert property (@(posedge clk) disable iff (rst)
        acc |=> blk_out[SEG_W-1:0] == $past(blk_out[SEG_W-1:0]) + SEG_W'(1));

    a_r4_hold: assert property (@(posedge clk) disable iff (rst)
        (!iv_load && !(adv_valid && adv_ready)) |=> $stable(blk_out));

    a_r6_nonce64: assert property (@(posedge clk) disable iff (rst)
        (acc && width_q == 2'b01) |=> $stable(blk_out[BLK_W-1:BLK_W/2]));

    a_r7_nonce96: assert property (@(posedge clk) disable iff (rst)
        (acc && width_q == 2'b10) |=> $stable(blk_out[BLK_W-1:BLK_W/4]));

    a_r8_wrap_sticky: assert property (@(posedge clk) disable iff (rst)
        (wrap_flag && !iv_load) |=> wrap_flag);

    a_r9_rise_needs_advance: assert property (@(posedge clk) disable iff (rst)
        $rose(wrap_flag) |-> $past(adv_valid && adv_ready));
endmodule

bind ctr_blockgen ctr_blockgen_chk #(.BLK_W(BLK_W), .SEG_W(SEG_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .iv_load   (iv_load),
    .iv_data   (iv_data),
    .adv_valid (adv_valid),
    .adv_ready (adv_ready),
    .blk_out   (blk_out),
    .wrap_flag (wrap_flag),
    .width_q   (st_q.width)
);

// File: tb/ctr_blockgen_test.sv
module ctr_blockgen_test;
    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         iv_load = 1'b0;
    logic [127:0] iv_data = '0;
    logic [1:0]   mode = 2'b00;
    logic         adv_valid = 1'b0;
    logic         adv_ready;
    logic [127:0] blk_out;
    logic         wrap_flag;

    int errors = 0;
    int checks = 0;
    bit done = 0;

    always #4 clk = ~clk;

    ctr_blockgen uut (
        .clk(clk), .rst(rst), .iv_load(iv_load), .iv_data(iv_data),
        .mode(mode), .adv_valid(adv_valid), .adv_ready(adv_ready),
        .blk_out(blk_out), .wrap_flag(wrap_flag)
    );

    localparam int NV = 9;
    localparam logic [1:0] V_MODE [NV] = '{2'b00, 2'b00, 2'b01, 2'b01, 2'b10, 2'b10, 2'b11, 2'b00, 2'b01};
    localparam logic [127:0] V_IV [NV] = '{
        128'h0,
        {64'h0, 64'hFFFF_FFFF_FFFF_FFFF},
        {64'hA5A5_A5A5_A5A5_A5A5, 64'hFFFF_FFFF_FFFF_FFFF},
        {64'h1234_5678_9ABC_DEF0, 64'h0000_0000_FFFF_FFFF},
        {96'hDEAD_BEEF_0123_4567_89AB_CDEF, 32'hFFFF_FFFE},
        {96'hC0FF_EE00_1111_2222_3333_4444, 32'h0000_00FF},
        {128{1'b1}},
        {128{1'b1}},
        {64'h0, 64'h7}};
    localparam int V_N [NV] = '{3, 1, 1, 1, 2, 1, 1, 1, 5};
    localparam logic [127:0] V_EXP [NV] = '{
        128'h3,
        {64'h1, 64'h0},
        {64'hA5A5_A5A5_A5A5_A5A5, 64'h0},
        {64'h1234_5678_9ABC_DEF0, 64'h0000_0001_0000_0000},
        {96'hDEAD_BEEF_0123_4567_89AB_CDEF, 32'h0},
        {96'hC0FF_EE00_1111_2222_3333_4444, 32'h0000_0100},
        128'h0,
        128'h0,
        {64'h0, 64'hC}};
    localparam logic V_WRAP [NV] = '{1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0};
    localparam string V_TAG [NV] = '{"R3", "R5", "R6", "R6", "R7", "R7", "R5", "R8", "R3"};

    task automatic check(input string tag, input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic do_load(input logic [1:0] m, input logic [127:0] v);
        @(negedge clk);
        iv_load = 1'b1; iv_data = v; mode = m;
        @(negedge clk);
        iv_load = 1'b0;
    endtask

    task automatic advance(input int n);
        @(negedge clk);
        adv_valid = 1'b1;
        for (int k = 1; k < n; k++) @(negedge clk);
        @(negedge clk);
        adv_valid = 1'b0;
    endtask

    initial begin
        #(8 * 100000);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        check("R1 ready", {127'h0, adv_ready}, 128'h0);
        check("R1 wrap", {127'h0, wrap_flag}, 128'h0);
        check("R1 block", blk_out, 128'h0);
        // R4 advance before any load is ignored
        advance(2);
        check("R4 pre-load", blk_out, 128'h0);

        for (int i = 0; i < NV; i++) begin
            do_load(V_MODE[i], V_IV[i]);
            check("R2 load", blk_out, V_IV[i]);
            advance(V_N[i]);
            check(V_TAG[i], blk_out, V_EXP[i]);
            check({V_TAG[i], " R8 flag"}, {127'h0, wrap_flag}, {127'h0, V_WRAP[i]});
        end

        // R4 hold with valid low
        do_load(2'b00, 128'h55);
        repeat (3) @(negedge clk);
        check("R4 hold", blk_out, 128'h55);

        // R2 load wins over same-cycle advance
        @(negedge clk);
        iv_load = 1'b1; iv_data = 128'h5; adv_valid = 1'b1;
        @(negedge clk);
        iv_load = 1'b0; adv_valid = 1'b0;
        check("R2 priority", blk_out, 128'h5);

        // R8 sticky through later advances, R9 cleared by load
        do_load(2'b10, {96'h1, 32'hFFFF_FFFF});
        advance(1);
        check("R7 roll", blk_out, {96'h1, 32'h0});
        advance(2);
        check("R8 after", blk_out, {96'h1, 32'h2});
        check("R8 sticky", {127'h0, wrap_flag}, 128'h1);
        repeat (2) @(negedge clk);
        check("R9 idle keeps", {127'h0, wrap_flag}, 128'h1);
        do_load(2'b10, 128'h9);
        check("R9 cleared", {127'h0, wrap_flag}, 128'h0);

        // R10 width latched at load
        do_load(2'b10, {96'h5, 32'hFFFF_FFFF});
        mode = 2'b00;
        advance(1);
        check("R10 latched", blk_out, {96'h5, 32'h0});
        check("R10 flag", {127'h0, wrap_flag}, 128'h1);

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule